// File: doc/BRIEF.md
# Burst Address Counter with Load

This block generates the internal address of one port of a synchronous memory. At every rising clock edge it samples three active-low strobes and an external address bus, and picks the address for the access in that cycle. It can clear the address to zero, capture the external address, step the previously used address by one, or reuse the previously used address unchanged. The chosen address drives the memory core for the access. A two-bit code tells which of the four choices was taken.

The choices follow a fixed priority: clear beats load, and load beats increment. Hold is the fallback when no strobe is active. Nothing else qualifies the strobes, so the counter keeps loading or stepping while the memory port is deselected. A clear cycle is not a dead cycle: the access in that cycle uses address zero, and the next cycle can step on from there at once. Stepping past the all-ones address wraps to zero.

Top module: `burst_addr_gen`

## Requirements
- R1: With `clr_n` low at a rising edge, `addr_o` is 0 after that edge and `mode_o` is 2'b11, whatever `ld_n`, `adv_n` and `ext_addr` hold.
- R2: With `clr_n` high and `ld_n` low at a rising edge, `addr_o` equals the `ext_addr` sampled at that edge and `mode_o` is 2'b10, whatever `adv_n` holds.
- R3: With `clr_n` and `ld_n` high and `adv_n` low at a rising edge, `addr_o` becomes its previous value plus one and `mode_o` is 2'b01.
- R4: A step from the all-ones address (0x1FFFF for the default 17-bit width) gives 0.
- R5: With `clr_n`, `ld_n` and `adv_n` all high at a rising edge, `addr_o` keeps its previous value, any new `ext_addr` value has no effect, and `mode_o` is 2'b00.
- R6: A clear cycle adds no dead cycle: a step in the cycle right after a clear gives address 1, and a step may follow on every edge without any enable other than `adv_n`.
- R7: With `rst_n` low at a rising edge, `addr_o` is 0 and `mode_o` is 2'b00 after that edge, whatever the strobes hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous design reset, active low |
| clr_n | input | 1 | Counter clear strobe, active low, highest priority |
| ld_n | input | 1 | External address load strobe, active low |
| adv_n | input | 1 | Counter advance enable, active low |
| ext_addr | input | ADDR_W (17) | External address bus |
| addr_o | output | ADDR_W (17) | Internal address for the memory core |
| mode_o | output | 2 | Choice taken: 00 hold, 01 step, 10 load, 11 clear |

## Verification
Every result is due one clock after the edge that samples its stimulus. The address and the mode code are registered, and there is no other stage on the way. The bench changes inputs on the falling edge. It compares both outputs a short delay after the next rising edge, against a model that applies the priority rules to its own copy of the previous address. Each of the eight strobe combinations is swept from several starting addresses, including all-ones, so each sweep covers a choice result and, for the step, the wrap. A long stepping run after a clear confirms that the address moves on every edge with no gap.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Code reported on mode_o; the value order is part of the port contract.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_STEP  = 2'b01,
        MODE_LOAD  = 2'b10,
        MODE_CLEAR = 2'b11
    } addr_mode_e;

endpackage

// File: rtl/bag_mode_sel.sv
module bag_mode_sel
    import burst_addr_pkg::*;
(
    input  logic       clr_n,
    input  logic       ld_n,
    input  logic       adv_n,
    output addr_mode_e mode
);

    // Fixed priority: clear, then load, then step, else hold.
    always_comb begin
        if (!clr_n) begin
            mode = MODE_CLEAR;
        end else if (!ld_n) begin
            mode = MODE_LOAD;
        end else if (!adv_n) begin
            mode = MODE_STEP;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/bag_incr.sv
module bag_incr #(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] a,
    output logic [ADDR_W-1:0] sum
);

    // Half-adder ripple chain; carry out of the top bit is dropped (wrap).
    logic [ADDR_W-1:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 1; i < ADDR_W; i++) begin : g_carry
        assign carry[i] = carry[i-1] & a[i-1];
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_sum
        assign sum[i] = a[i] ^ carry[i];
    end

endmodule

// File: rtl/bag_addr_reg.sv
module bag_addr_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_mode_e        mode,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] addr_inc,
    output logic [ADDR_W-1:0] addr_q,
    output addr_mode_e        mode_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        addr_mode_e        mode;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode;
        case (mode)
            MODE_CLEAR: st_d.addr = '0;
            MODE_LOAD:  st_d.addr = ext_addr;
            MODE_STEP:  st_d.addr = addr_inc;
            default:    st_d.addr = st_q.addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.mode <= MODE_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q = st_q.addr;
    assign mode_q = st_q.mode;

    // R7: design reset leaves address zero and the hold code.
    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> (addr_q == '0 && mode_q == MODE_HOLD));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ld_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        mode_o
);

    localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

    addr_mode_e        mode_sel;
    addr_mode_e        mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_inc;

    bag_mode_sel u_mode_sel (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .adv_n (adv_n),
        .mode  (mode_sel)
    );

    bag_incr #(.ADDR_W(ADDR_W)) u_incr (
        .a   (addr_q),
        .sum (addr_inc)
    );

    bag_addr_reg #(.ADDR_W(ADDR_W)) u_addr_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_sel),
        .ext_addr (ext_addr),
        .addr_inc (addr_inc),
        .addr_q   (addr_q),
        .mode_q   (mode_q)
    );

    assign addr_o = addr_q;
    assign mode_o = mode_q;

    // R1: clear wins over every other strobe.
    p_clear_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (addr_o == '0 && mode_o == 2'b11));

    // R2: load captures the sampled external address.
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n) |=> (addr_o == $past(ext_addr) && mode_o == 2'b10));

    // R3: step adds one to the previous address.
    p_step_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !adv_n) |=>
            (addr_o == ADDR_W'($past(addr_o) + 1'b1) && mode_o == 2'b01));

    // R4: stepping from all-ones wraps to zero.
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !adv_n && addr_o == ADDR_MAX) |=> (addr_o == '0));

    // R5: with no strobe the address holds.
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && adv_n) |=> ($stable(addr_o) && mode_o == 2'b00));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int ADDR_W = 17;
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_n = 1'b1;
    logic              ld_n = 1'b1;
    logic              adv_n = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic [ADDR_W-1:0] addr_o;
    logic [1:0]        mode_o;

    int checks = 0;
    int errors = 0;
    logic [ADDR_W-1:0] exp_addr = '0;
    logic [1:0]        exp_mode = 2'b00;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .adv_n    (adv_n),
        .ext_addr (ext_addr),
        .addr_o   (addr_o),
        .mode_o   (mode_o)
    );

    task automatic check(input string req);
        checks++;
        if (addr_o !== exp_addr || mode_o !== exp_mode) begin
            errors++;
            $display("FAIL %s: addr=%h mode=%b expected addr=%h mode=%b",
                     req, addr_o, mode_o, exp_addr, exp_mode);
        end
    endtask

    // Drive at the falling edge, update the model, sample 2 ns after the rising edge.
    task automatic step(input logic c, input logic l, input logic a,
                        input logic [ADDR_W-1:0] ext, input string req);
        @(negedge clk);
        clr_n = c; ld_n = l; adv_n = a; ext_addr = ext;
        if (!c) begin
            exp_addr = '0;            exp_mode = 2'b11;
        end else if (!l) begin
            exp_addr = ext;           exp_mode = 2'b10;
        end else if (!a) begin
            exp_addr = exp_addr + 1'b1; exp_mode = 2'b01;
        end else begin
            exp_mode = 2'b00;
        end
        @(posedge clk);
        #2;
        check(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] starts [5];
        starts[0] = '0;
        starts[1] = 17'h00005;
        starts[2] = ALL_ONES;
        starts[3] = 17'h10000;
        starts[4] = 17'h0ABCD;

        // R7: reset with every strobe active still gives zero and hold.
        clr_n = 1'b0; ld_n = 1'b0; adv_n = 1'b0; ext_addr = 17'h1234;
        repeat (3) @(posedge clk);
        #2;
        exp_addr = '0; exp_mode = 2'b00;
        check("R7");
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep all strobe combinations from several starting addresses.
        for (int s = 0; s < 5; s++) begin
            for (int combo = 0; combo < 8; combo++) begin
                string req;
                step(1'b1, 1'b0, 1'b1, starts[s], "R2");
                if (combo[2] == 1'b0)      req = "R1";
                else if (combo[1] == 1'b0) req = "R2";
                else if (combo[0] == 1'b0) req = (starts[s] == ALL_ONES) ? "R4" : "R3";
                else                       req = "R5";
                step(combo[2], combo[1], combo[0], ~starts[s], req);
            end
        end

        // R5: ext_addr changes under hold have no effect over several cycles.
        step(1'b1, 1'b0, 1'b1, 17'h01357, "R2");
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b1, 1'b1, 17'(k * 17'h0F0F1), "R5");
        end

        // R4: explicit wrap from all-ones, then one more step.
        step(1'b1, 1'b0, 1'b1, ALL_ONES, "R2");
        step(1'b1, 1'b1, 1'b0, 17'h0, "R4");
        step(1'b1, 1'b1, 1'b0, 17'h0, "R3");

        // R6: clear, then step on every edge with no gap.
        step(1'b0, 1'b1, 1'b1, 17'h1AAAA, "R1");
        for (int k = 0; k < 20; k++) begin
            step(1'b1, 1'b1, 1'b0, 17'h1AAAA, "R6");
        end
        if (addr_o !== 17'd20) begin
            errors++;
            $display("FAIL R6: addr=%h expected addr=%h", addr_o, 17'd20);
        end
        checks++;

        // R7: mid-run reset clears a loaded address.
        step(1'b1, 1'b0, 1'b1, 17'h0BEEF, "R2");
        @(negedge clk);
        rst_n = 1'b0; clr_n = 1'b1; ld_n = 1'b0; adv_n = 1'b0;
        @(posedge clk);
        #2;
        exp_addr = '0; exp_mode = 2'b00;
        check("R7");
        @(negedge clk);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule